// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Protection

This block caches recent virtual-to-physical page translations for 32-bit addresses and 4 KB pages. A lookup presents a virtual address, an access kind (read, write or execute), the privilege mode of the requester and a process number. The virtual page number and the process number are compared against all sixteen slots in one cycle. One clock later the block reports exactly one outcome. A good translation returns the frame number joined to the untranslated page offset. The other outcomes are a miss, which tells the caller to consult the page table, a page fault on a match whose page is not resident, and a protection fault when the rights stored with the match forbid the access.

Privileged software fills the buffer through a separate write port. Each slot carries a process tag, a resident bit and read, write, execute and user-access permission bits. An install lands in the slot already holding the same page and process if there is one. If not, it takes the lowest free slot, and failing that it evicts the least recently used slot, tracked by per-slot age counters. Two flush inputs invalidate either every slot or only the slots of one process, in a single cycle.

Top module: `xlat_tlb`

## Requirements
- R1: One cycle after a lookup that hits with sufficient rights, `rs_hit` is 1 and `rs_paddr` equals the stored 20-bit frame number in bits 31:12 and lookup address bits 11:0 below it.
- R2: A slot matches only when both its page number (address bits 31:12) and its process tag equal the lookup's, so one page number can map to different frames for different processes.
- R3: A lookup that matches no occupied slot raises `rs_miss`.
- R4: A matching slot whose resident bit (permission bit 0) is clear raises `rs_pfault`, and this takes priority over any rights violation.
- R5: Access kind 0 (read) needs permission bit 1, kind 1 (write) needs bit 2, kind 2 (execute) needs bit 3, and kind 3 is never allowed. A resident match lacking the needed bit raises `rs_prot`.
- R6: With `lk_kmode` 0, a resident match whose user bit (permission bit 4) is clear raises `rs_prot`. With `lk_kmode` 1 the user bit is not consulted.
- R7: A write with `wr_kmode` 0 is ignored and leaves the contents unchanged.
- R8: An install whose page and process already occupy a slot overwrites that slot. Otherwise it uses a free slot before evicting any occupied one.
- R9: When every slot is occupied, an install evicts the slot least recently installed or matched by a lookup.
- R10: `fl_all` invalidates every slot by the next cycle.
- R11: `fl_pid_en` invalidates only the slots whose process tag equals `fl_pid`.
- R12: `rs_valid` follows `lk_req` by exactly one cycle, and while it is 1 exactly one of `rs_hit`, `rs_miss`, `rs_pfault` and `rs_prot` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_kmode | input | 1 | 1 when the requester is in kernel mode |
| lk_pid | input | 4 | Process number of the requester |
| wr_en | input | 1 | Install request |
| wr_kmode | input | 1 | 1 when the installer is in kernel mode |
| wr_vpn | input | 20 | Page number to install |
| wr_pid | input | 4 | Process tag to install |
| wr_pfn | input | 20 | Frame number to install |
| wr_perm | input | 5 | {user, exec, write, read, resident} |
| fl_all | input | 1 | Invalidate every slot |
| fl_pid_en | input | 1 | Invalidate the slots of one process |
| fl_pid | input | 4 | Process whose slots are invalidated |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No slot matched |
| rs_pfault | output | 1 | Matched page is not resident |
| rs_prot | output | 1 | Access rights violated |
| rs_paddr | output | 32 | Physical address, meaningful with `rs_hit` |

## Verification
A table of lookups is run against four installed pages. Two of them share a page number but belong to different processes, which separates a correct process compare from a page-only compare. The other two are a non-resident page and a supervisor-only page, and each access kind and privilege mode is tried against them to show the fault priority and the rights decode. Directed sequences fill all sixteen slots in a known order and refresh one of them. They show that the evicted page is the oldest one, that an install first reuses a slot freed by a per-process flush while the oldest page survives, and that a repeated install replaces the frame in place.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  // bit 0 resident .. bit 4 user-accessible
  typedef struct packed {
    logic usr;
    logic ex;
    logic wr;
    logic rd;
    logic res;
  } perm_t;

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 4
) (
  input  logic [N-1:0]            occ,
  input  logic [N-1:0][VPN_W-1:0] tag_vpn,
  input  logic [N-1:0][PID_W-1:0] tag_pid,
  input  logic [VPN_W-1:0]        q_vpn,
  input  logic [PID_W-1:0]        q_pid,
  output logic [N-1:0]            hit_vec
);

  // R2: page number and process tag must both agree
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = occ[g] && (tag_vpn[g] == q_vpn) && (tag_pid[g] == q_pid);
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  perm_t      perm,
  input  logic [1:0] kind,
  input  logic       kmode,
  output logic       ok
);

  logic right;

  // R5: rights decode, R6: user bit only consulted outside kernel mode
  always_comb begin
    unique case (acc_e'(kind))
      ACC_READ:  right = perm.rd;
      ACC_WRITE: right = perm.wr;
      ACC_EXEC:  right = perm.ex;
      default:   right = 1'b0;
    endcase
    ok = right && (kmode || perm.usr);
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     occ,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [N-1:0][IDX_W-1:0] age;
  logic [N-1:0]            oldest;
  logic                    have_free;

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age[g] == OLDEST);
  end

  // ages form a permutation of 0..N-1; a touch moves one slot to 0
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)
          age[i] <= '0;
        else if (age[i] < age[touch_idx])
          age[i] <= age[i] + 1'b1;
      end
    end
  end

  // R8: free slot first (lowest index), R9: else the oldest slot
  always_comb begin
    victim_idx = '0;
    have_free  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!occ[i] && !have_free) begin
        victim_idx = IDX_W'(i);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++) begin
        if (oldest[i]) victim_idx = IDX_W'(i);
      end
    end
  end

  a_r9_single_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);

  a_r9_touched_is_newest: assert property (@(posedge clk) disable iff (rst)
    touch |=> age[$past(touch_idx)] == '0);

endmodule

// File: rtl/tlb_pfn_ram.sv
module tlb_pfn_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 20,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_req,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_kind,
  input  logic                  lk_kmode,
  input  logic [PID_W-1:0]      lk_pid,
  input  logic                  wr_en,
  input  logic                  wr_kmode,
  input  logic [VA_W-OFF_W-1:0] wr_vpn,
  input  logic [PID_W-1:0]      wr_pid,
  input  logic [PA_W-OFF_W-1:0] wr_pfn,
  input  logic [4:0]            wr_perm,
  input  logic                  fl_all,
  input  logic                  fl_pid_en,
  input  logic [PID_W-1:0]      fl_pid,
  output logic                  rs_valid,
  output logic                  rs_hit,
  output logic                  rs_miss,
  output logic                  rs_pfault,
  output logic                  rs_prot,
  output logic [PA_W-1:0]       rs_paddr
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // slot state kept in flops so every slot is compared at once
  logic [ENTRIES-1:0]            occ;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_vpn;
  logic [ENTRIES-1:0][PID_W-1:0] tag_pid;
  perm_t [ENTRIES-1:0]           perm;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] hit_vec, wmatch_vec;
  logic               hit_any, wmatch_any;
  logic [IDX_W-1:0]   hit_idx, wmatch_idx, victim_idx, wr_idx, touch_idx;
  perm_t              hit_perm;
  logic               rights_ok;
  logic               wr_ok, touch;
  logic [PFN_W-1:0]   pfn_q;
  logic [OFF_W-1:0]   off_q;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  tlb_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cmp (
    .occ(occ), .tag_vpn(tag_vpn), .tag_pid(tag_pid),
    .q_vpn(lk_vpn), .q_pid(lk_pid), .hit_vec(hit_vec)
  );

  tlb_cam_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_wr_cmp (
    .occ(occ), .tag_vpn(tag_vpn), .tag_pid(tag_pid),
    .q_vpn(wr_vpn), .q_pid(wr_pid), .hit_vec(wmatch_vec)
  );

  assign hit_any    = |hit_vec;
  assign wmatch_any = |wmatch_vec;

  // one-hot to index; match vectors hold at most one bit
  always_comb begin
    hit_idx    = '0;
    wmatch_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i])    hit_idx    = hit_idx    | IDX_W'(i);
      if (wmatch_vec[i]) wmatch_idx = wmatch_idx | IDX_W'(i);
    end
  end

  assign hit_perm = perm[hit_idx];

  tlb_perm_check u_perm (
    .perm(hit_perm), .kind(lk_kind), .kmode(lk_kmode), .ok(rights_ok)
  );

  // R7: only kernel-mode writes install
  assign wr_ok  = wr_en && wr_kmode;
  // R8: reuse the slot of the same page/process, else the chosen victim
  assign wr_idx = wmatch_any ? wmatch_idx : victim_idx;

  assign touch     = wr_ok || (lk_req && hit_any);
  assign touch_idx = wr_ok ? wr_idx : hit_idx;

  tlb_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .occ(occ), .victim_idx(victim_idx)
  );

  // R10, R11: flushes; a same-cycle install wins for its own slot
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_ok && (wr_idx == IDX_W'(i)))
          occ[i] <= 1'b1;
        else if (fl_all)
          occ[i] <= 1'b0;
        else if (fl_pid_en && (tag_pid[i] == fl_pid))
          occ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_ok && (wr_idx == IDX_W'(i))) begin
        tag_vpn[i] <= wr_vpn;
        tag_pid[i] <= wr_pid;
        perm[i]    <= perm_t'(wr_perm);
      end
    end
  end

  tlb_pfn_ram #(.DEPTH(ENTRIES), .W(PFN_W), .AW(IDX_W)) u_pfn (
    .clk(clk), .we(wr_ok), .wa(wr_idx), .wd(wr_pfn),
    .re(lk_req), .ra(hit_idx), .rd(pfn_q)
  );

  // R3, R4, R5, R12: registered outcome, page fault ahead of rights
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_miss   <= 1'b0;
      rs_pfault <= 1'b0;
      rs_prot   <= 1'b0;
      off_q     <= '0;
    end else begin
      rs_valid  <= lk_req;
      rs_miss   <= lk_req && !hit_any;
      rs_pfault <= lk_req && hit_any && !hit_perm.res;
      rs_prot   <= lk_req && hit_any && hit_perm.res && !rights_ok;
      rs_hit    <= lk_req && hit_any && hit_perm.res && rights_ok;
      if (lk_req) off_q <= lk_off;
    end
  end

  // R1: frame number joined to the untranslated offset
  assign rs_paddr = {pfn_q, off_q};

  a_r2_unique_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rs_valid);

  a_r12_no_resp_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rs_valid);

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> $countones({rs_hit, rs_miss, rs_pfault, rs_prot}) == 1);

  a_r7_user_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_kmode && !fl_all && !fl_pid_en) |=> ($stable(occ) && $stable(tag_vpn)));

  a_r10_flush_all: assert property (@(posedge clk) disable iff (rst)
    (fl_all && !wr_ok) |=> occ == '0);

  a_r11_flush_adds_none: assert property (@(posedge clk) disable iff (rst)
    (fl_pid_en && !wr_ok) |=> (occ & ~$past(occ)) == '0);

endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_kmode = 1'b0;
  logic [3:0]  lk_pid = '0;
  logic        wr_en = 1'b0;
  logic        wr_kmode = 1'b0;
  logic [19:0] wr_vpn = '0;
  logic [3:0]  wr_pid = '0;
  logic [19:0] wr_pfn = '0;
  logic [4:0]  wr_perm = '0;
  logic        fl_all = 1'b0;
  logic        fl_pid_en = 1'b0;
  logic [3:0]  fl_pid = '0;
  logic        rs_valid, rs_hit, rs_miss, rs_pfault, rs_prot;
  logic [31:0] rs_paddr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  xlat_tlb u0 (.*);

  // outcome codes: 0 hit, 1 miss, 2 page fault, 3 protection
  localparam logic [1:0] O_HIT = 2'd0, O_MISS = 2'd1, O_PF = 2'd2, O_PROT = 2'd3;
  // permission bits {user, exec, write, read, resident}
  localparam logic [4:0] P_FULL = 5'b11111;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        km;
    logic [3:0]  pid;
    logic [1:0]  code;
    logic [31:0] pa;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{32'h0000_0100, 2'd0, 1'b0, 4'd1, 2'd0, 32'h4000_0100, 4'd1},  // R1
    '{32'h0000_0100, 2'd0, 1'b0, 4'd2, 2'd0, 32'h5000_0100, 4'd2},  // R2
    '{32'h0000_0100, 2'd1, 1'b0, 4'd2, 2'd3, 32'h0,         4'd5},  // R5 write w/o right
    '{32'h0000_0100, 2'd2, 1'b0, 4'd1, 2'd3, 32'h0,         4'd5},  // R5 exec w/o right
    '{32'h0000_0FFF, 2'd2, 1'b0, 4'd2, 2'd0, 32'h5000_0FFF, 4'd1},  // R1 top offset
    '{32'h0000_0100, 2'd3, 1'b1, 4'd1, 2'd3, 32'h0,         4'd5},  // R5 kind 3
    '{32'h0000_0100, 2'd0, 1'b0, 4'd3, 2'd1, 32'h0,         4'd2},  // R2 other pid
    '{32'h1234_5678, 2'd0, 1'b1, 4'd1, 2'd2, 32'h0,         4'd4},  // R4
    '{32'h1234_5000, 2'd3, 1'b0, 4'd1, 2'd2, 32'h0,         4'd4},  // R4 beats rights
    '{32'h7FFF_F004, 2'd0, 1'b0, 4'd1, 2'd3, 32'h0,         4'd6},  // R6 user
    '{32'h7FFF_F004, 2'd2, 1'b1, 4'd1, 2'd0, 32'h00FF_F004, 4'd6},  // R6 kernel
    '{32'h0000_1100, 2'd0, 1'b0, 4'd1, 2'd1, 32'h0,         4'd3}   // R3
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic install(input logic [19:0] vpn, input logic [3:0] pid,
                         input logic [19:0] pfn, input logic [4:0] pm, input logic km);
    @(negedge clk);
    wr_en = 1'b1; wr_kmode = km; wr_vpn = vpn; wr_pid = pid; wr_pfn = pfn; wr_perm = pm;
    @(negedge clk);
    wr_en = 1'b0; wr_kmode = 1'b0;
  endtask

  task automatic flush(input logic all, input logic pe, input logic [3:0] pid);
    @(negedge clk);
    fl_all = all; fl_pid_en = pe; fl_pid = pid;
    @(negedge clk);
    fl_all = 1'b0; fl_pid_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic km,
                        input logic [3:0] pid, input logic [1:0] code,
                        input logic [31:0] pa, input string req);
    logic [3:0] exp_f, act_f;
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_kind = kind; lk_kmode = km; lk_pid = pid;
    @(negedge clk);
    lk_req = 1'b0;
    exp_f = 4'b1000 >> code;
    act_f = {rs_hit, rs_miss, rs_pfault, rs_prot};
    chk(rs_valid && act_f == exp_f, req, "outcome {valid,hit,miss,pf,prot}",
        {27'd0, rs_valid, act_f}, {27'd0, 1'b1, exp_f});
    if (code == O_HIT)
      chk(rs_paddr == pa, req, "paddr", rs_paddr, pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: no response, table empty (R12, R3)
    chk(rs_valid == 1'b0, "R12", "valid after reset", {31'd0, rs_valid}, 32'd0);
    lookup(32'h0000_0100, 2'd0, 1'b1, 4'd1, O_MISS, 32'h0, "R3");
    @(negedge clk);
    chk(rs_valid == 1'b0, "R12", "valid on idle cycle", {31'd0, rs_valid}, 32'd0);

    install(20'h00000, 4'd1, 20'h40000, 5'b10111, 1'b1); // rd wr usr
    install(20'h00000, 4'd2, 20'h50000, 5'b11011, 1'b1); // rd ex usr
    install(20'h12345, 4'd1, 20'hABCDE, 5'b11110, 1'b1); // not resident
    install(20'h7FFFF, 4'd1, 20'h00FFF, 5'b01111, 1'b1); // supervisor only

    for (int k = 0; k < 12; k++) begin
      string tag;
      tag = $sformatf("R%0d", VT[k].req);
      lookup(VT[k].va, VT[k].kind, VT[k].km, VT[k].pid, VT[k].code, VT[k].pa, tag);
    end

    // R7: user-mode install has no effect
    install(20'h22222, 4'd1, 20'h33333, P_FULL, 1'b0);
    lookup(32'h2222_2000, 2'd0, 1'b1, 4'd1, O_MISS, 32'h0, "R7");

    // R8: re-install of an existing page replaces its frame in place
    install(20'h00000, 4'd1, 20'h41111, 5'b10111, 1'b1);
    lookup(32'h0000_0100, 2'd0, 1'b0, 4'd1, O_HIT, 32'h4111_1100, "R8");

    // R11: per-process flush
    flush(1'b0, 1'b1, 4'd2);
    lookup(32'h0000_0100, 2'd0, 1'b0, 4'd2, O_MISS, 32'h0, "R11");
    lookup(32'h0000_0100, 2'd0, 1'b0, 4'd1, O_HIT, 32'h4111_1100, "R11");

    // R10: flush all
    flush(1'b1, 1'b0, 4'd0);
    lookup(32'h0000_0100, 2'd0, 1'b0, 4'd1, O_MISS, 32'h0, "R10");
    lookup(32'h7FFF_F000, 2'd0, 1'b1, 4'd1, O_MISS, 32'h0, "R10");

    // R9: fill 16 slots, refresh the oldest, then evict
    for (int k = 0; k < 16; k++) install(20'h00100 + 20'(k), 4'd5, 20'h00200 + 20'(k), P_FULL, 1'b1);
    lookup(32'h0010_0000, 2'd0, 1'b0, 4'd5, O_HIT, 32'h0020_0000, "R9");
    install(20'h00300, 4'd5, 20'h00400, P_FULL, 1'b1);
    lookup(32'h0010_1000, 2'd0, 1'b0, 4'd5, O_MISS, 32'h0, "R9");
    lookup(32'h0030_0abc, 2'd0, 1'b0, 4'd5, O_HIT, 32'h0040_0abc, "R9");
    lookup(32'h0010_0010, 2'd0, 1'b0, 4'd5, O_HIT, 32'h0020_0010, "R9");

    // R8: a freed slot is used before the oldest page is evicted
    flush(1'b1, 1'b0, 4'd0);
    for (int k = 0; k < 8; k++) install(20'h00500 + 20'(k), 4'd5, 20'h00600 + 20'(k), P_FULL, 1'b1);
    install(20'h00700, 4'd6, 20'h00800, P_FULL, 1'b1);
    for (int k = 8; k < 15; k++) install(20'h00500 + 20'(k), 4'd5, 20'h00600 + 20'(k), P_FULL, 1'b1);
    flush(1'b0, 1'b1, 4'd6);
    install(20'h00900, 4'd5, 20'h00A00, P_FULL, 1'b1);
    lookup(32'h0090_0004, 2'd0, 1'b0, 4'd5, O_HIT, 32'h00A0_0004, "R8");
    lookup(32'h0050_0008, 2'd0, 1'b0, 4'd5, O_HIT, 32'h0060_0008, "R8");
    lookup(32'h0070_0000, 2'd0, 1'b0, 4'd6, O_MISS, 32'h0, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule